// File: doc/BRIEF.md
# Event Combiner and Interrupt Selector

This block gathers 128 peripheral event lines into four groups of 32. Each event has a sticky flag. A rising edge on the event line sets the flag, and only software clears it. Software can also set or clear any flag directly, and can mask each event individually. Every group ORs its unmasked flags into one combined request. These four combined requests come back as event numbers 0 to 3. Any event number can then be steered onto one of twelve core interrupt lines. Line i serves core vector i+4.

A second mask per event gives a separate view of the same flags. The OR of that view over all groups forms a single exception output. Software can also write an event number to an assert register, which raises a one-cycle pulse carrying that number. All registers sit behind a plain word-addressed write/read bus. Read data is registered and appears one cycle after the address.

Top module: `evt_combiner_sel`

## Requirements
- R1: A rising edge on `evt_in[n]` sets flag n. The flag stays set after the input falls. Event n is bit n mod 32 of group n/32.
- R2: Writing a group's set register (address 0x04+g) sets the flags whose data bits are 1. Writing its clear register (0x08+g) clears the flags whose data bits are 1. Data bits that are 0 leave their flags unchanged.
- R3: If a hardware rising edge and a software clear hit the same flag in the same cycle, the flag ends up set.
- R4: The masked-flag register (0x10+g, read-only) equals flag AND NOT mask. The mask is read and written at 0x0C+g, and a mask bit of 1 blocks its event. `comb_out[g]` is 1 exactly while this value is nonzero.
- R5: After reset, all flags read 0, all mask and exception-mask bits read 1, all selector fields read 0, and every output is low.
- R6: Flag bits 0 to 3 of group 0 always read 0. Edges on `evt_in[3:0]` and set writes to those bits have no effect.
- R7: Selector register r (0x1C+r, r = 0..2) holds four 8-bit fields. The field for line i sits in register i/4 at bit offset (i mod 4)*8. The line behaves as follows:
  - For a field value s from 4 to 127, `int_out[i]` follows flag s, whatever that event's mask.
  - For s from 0 to 3, the line follows `comb_out[s]`.
  - For s of 128 or more, the line is 0.
- R8: The masked-exception register (0x18+g, read-only) equals flag AND NOT exception mask. The exception mask is at 0x14+g. `exc_out` is 1 while any group's masked-exception value is nonzero.
- R9: A write to 0x20 drives `asrt_valid` high for one cycle, with `asrt_id` equal to `bus_wdata[6:0]`.
- R10: Writes to the flag register (0x00+g) and to the two masked views leave all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 128 | Peripheral event lines |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| comb_out | output | 4 | Combined request per group |
| int_out | output | 12 | Core interrupt lines (vectors 4..15) |
| exc_out | output | 1 | Exception request |
| asrt_valid | output | 1 | Event-assert pulse |
| asrt_id | output | 7 | Asserted event number |

## Verification
The bench drives a rising edge and a software clear onto the same flag in the same cycle. A design that let the clear win would lose the event. It steers one line to an event that is masked in the combiner and expects the line high anyway. A design that used the masked view there would keep the line silent. It also uses a field of 128 or more, which must yield 0 rather than wrap onto a low event. It pulses `evt_in[2]` and writes set bits 0 to 3 of group 0. A design without the reserved bits would feed group 0's combined request back into itself.

// File: rtl/ecs_pkg.sv
package ecs_pkg;
  localparam int NGRP = 4;
  localparam int GW   = 32;
  localparam int NOUT = 12;
  localparam int FW   = 8;
  localparam int AW   = 6;

  // register kind, taken from bus_addr[5:2]; bus_addr[1:0] selects the group
  typedef enum logic [3:0] {
    K_FLAG = 4'd0, K_SET = 4'd1, K_CLR = 4'd2, K_MASK = 4'd3,
    K_MFLG = 4'd4, K_EMSK = 4'd5, K_EFLG = 4'd6, K_SEL = 4'd7,
    K_ASRT = 4'd8
  } reg_kind_e;
endpackage

// File: rtl/ecs_group.sv
module ecs_group #(
  parameter int GW   = 32,
  parameter int RSVD = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [GW-1:0] evt,
  input  logic [GW-1:0] wdata,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic          mask_we,
  input  logic          emask_we,
  output logic [GW-1:0] flag,
  output logic [GW-1:0] mask,
  output logic [GW-1:0] emask,
  output logic [GW-1:0] mflag,
  output logic [GW-1:0] eflag,
  output logic          comb
);
  localparam logic [GW-1:0] KEEP = {GW{1'b1}} << RSVD;

  logic [GW-1:0] evt_q, set_bits, clr_bits;

  always_comb begin
    set_bits = (evt & ~evt_q & KEEP) | (set_we ? (wdata & KEEP) : '0);
    clr_bits = clr_we ? wdata : '0;
    mflag    = flag & ~mask;
    eflag    = flag & ~emask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      flag  <= '0;
      mask  <= '1;
      emask <= '1;
      comb  <= 1'b0;
    end else begin
      evt_q <= evt;
      flag  <= (flag & ~clr_bits) | set_bits;
      if (mask_we)  mask  <= wdata;
      if (emask_we) emask <= wdata;
      comb  <= |mflag;
    end
  end

  assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (|set_bits) |=> ((flag & $past(set_bits)) == $past(set_bits)));

  assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (|clr_bits) |=> ((flag & $past(clr_bits) & ~$past(set_bits)) == '0));

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (rst)
    ((flag & ~KEEP) == '0));

  assert_reset_masks_R5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask == '1 && emask == '1 && flag == '0));
endmodule

// File: rtl/ecs_route.sv
module ecs_route #(
  parameter int NEVT = 128,
  parameter int NGRP = 4,
  parameter int FW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [FW-1:0]   field,
  input  logic [NEVT-1:0] flags,
  input  logic [NGRP-1:0] comb,
  output logic            line
);
  localparam int EW = $clog2(NEVT);
  localparam int GB = $clog2(NGRP);

  always_ff @(posedge clk) begin
    if (rst)                      line <= 1'b0;
    else if (int'(field) < NGRP)  line <= comb[field[GB-1:0]];
    else if (int'(field) < NEVT)  line <= flags[field[EW-1:0]];
    else                          line <= 1'b0;
  end

  assert_route_range_R7: assert property (@(posedge clk) disable iff (rst)
    (int'(field) >= NEVT) |=> !line);

  assert_route_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (int'(field) >= NGRP && int'(field) < NEVT && flags[field[EW-1:0]]) |=> line);
endmodule

// File: rtl/evt_combiner_sel.sv
module evt_combiner_sel
  import ecs_pkg::*;
#(
  parameter int NG  = NGRP,
  parameter int W   = GW,
  parameter int NO  = NOUT,
  parameter int F   = FW,
  parameter int A   = AW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NG*W-1:0] evt_in,
  input  logic            bus_wr,
  input  logic [A-1:0]    bus_addr,
  input  logic [W-1:0]    bus_wdata,
  output logic [W-1:0]    bus_rdata,
  output logic [NG-1:0]   comb_out,
  output logic [NO-1:0]   int_out,
  output logic            exc_out,
  output logic            asrt_valid,
  output logic [$clog2(NG*W)-1:0] asrt_id
);
  localparam int NEVT = NG * W;
  localparam int EW   = $clog2(NEVT);
  localparam int FPR  = W / F;
  localparam int NSEL = (NO + FPR - 1) / FPR;

  logic [3:0]      kind;
  logic [1:0]      gsel;
  logic [NEVT-1:0] all_flag;
  logic [W-1:0]    flag_g [NG], mask_g [NG], emask_g [NG], mflag_g [NG], eflag_g [NG];
  logic [NG-1:0]   comb_g, exc_g;
  logic [W-1:0]    sel_q [NSEL];

  assign kind = bus_addr[A-1:2];
  assign gsel = bus_addr[1:0];

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic hit;
    assign hit = bus_wr && (int'(gsel) == g);
    ecs_group #(.GW(W), .RSVD(g == 0 ? NG : 0)) u_grp (
      .clk(clk), .rst(rst), .evt(evt_in[g*W +: W]), .wdata(bus_wdata),
      .set_we(hit && kind == K_SET), .clr_we(hit && kind == K_CLR),
      .mask_we(hit && kind == K_MASK), .emask_we(hit && kind == K_EMSK),
      .flag(flag_g[g]), .mask(mask_g[g]), .emask(emask_g[g]),
      .mflag(mflag_g[g]), .eflag(eflag_g[g]), .comb(comb_g[g]));
    assign all_flag[g*W +: W] = flag_g[g];
    assign exc_g[g] = |eflag_g[g];
  end

  assign comb_out = comb_g;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NSEL; r++) sel_q[r] <= '0;
    end else if (bus_wr && kind == K_SEL && int'(gsel) < NSEL) begin
      sel_q[gsel] <= bus_wdata;
    end
  end

  for (genvar i = 0; i < NO; i++) begin : g_route
    ecs_route #(.NEVT(NEVT), .NGRP(NG), .FW(F)) u_route (
      .clk(clk), .rst(rst), .field(sel_q[i / FPR][(i % FPR) * F +: F]),
      .flags(all_flag), .comb(comb_g), .line(int_out[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      exc_out    <= 1'b0;
      asrt_valid <= 1'b0;
      asrt_id    <= '0;
    end else begin
      exc_out    <= |exc_g;
      asrt_valid <= bus_wr && kind == K_ASRT && gsel == 2'd0;
      if (bus_wr && kind == K_ASRT && gsel == 2'd0) asrt_id <= bus_wdata[EW-1:0];
      case (kind)
        K_FLAG:  bus_rdata <= flag_g[gsel];
        K_MASK:  bus_rdata <= mask_g[gsel];
        K_MFLG:  bus_rdata <= mflag_g[gsel];
        K_EMSK:  bus_rdata <= emask_g[gsel];
        K_EFLG:  bus_rdata <= eflag_g[gsel];
        K_SEL:   bus_rdata <= (int'(gsel) < NSEL) ? sel_q[gsel] : '0;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assert_asrt_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && kind == K_ASRT && gsel == 2'd0) |=>
      (asrt_valid && asrt_id == $past(bus_wdata[EW-1:0])));

  assert_exc_any_R8: assert property (@(posedge clk) disable iff (rst)
    (|exc_g) |=> exc_out);

  assert_comb_follow_R4: assert property (@(posedge clk) disable iff (rst)
    (|mflag_g[1]) |=> comb_out[1]);
endmodule

// File: tb/evt_combiner_sel_tb.sv
`timescale 1ns/1ps
module evt_combiner_sel_tb;
  logic         clk = 0, rst = 1;
  logic [127:0] evt_in = '0;
  logic         bus_wr = 0;
  logic [5:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [3:0]   comb_out;
  logic [11:0]  int_out;
  logic         exc_out, asrt_valid;
  logic [6:0]   asrt_id;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evt_combiner_sel u_dut (
    .clk(clk), .rst(rst), .evt_in(evt_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .comb_out(comb_out),
    .int_out(int_out), .exc_out(exc_out), .asrt_valid(asrt_valid), .asrt_id(asrt_id));

  localparam logic [5:0] A_FLAG = 6'h00, A_SET = 6'h04, A_CLR = 6'h08, A_MASK = 6'h0C,
                         A_MFLG = 6'h10, A_EMSK = 6'h14, A_EFLG = 6'h18, A_SEL = 6'h1C,
                         A_ASRT = 6'h20;

  // {group, set pattern, mask, expected masked flags}
  localparam logic [97:0] TBL [6] = '{
    {2'd1, 32'h0000_00F0, 32'hFFFF_FF0F, 32'h0000_00F0},
    {2'd2, 32'h8000_0001, 32'h8000_0000, 32'h0000_0001},
    {2'd3, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_0000},
    {2'd1, 32'hA5A5_0000, 32'h0F0F_0000, 32'hA0A0_0000},
    {2'd2, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    {2'd3, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R5 reset state
    rd(A_MASK + 0, d);  chk("R5 mask0", d, 32'hFFFF_FFFF);
    rd(A_EMSK + 3, d);  chk("R5 emask3", d, 32'hFFFF_FFFF);
    rd(A_FLAG + 2, d);  chk("R5 flag2", d, 32'h0);
    rd(A_SEL + 1, d);   chk("R5 sel1", d, 32'h0);
    chk("R5 outputs", {19'd0, comb_out, int_out, exc_out, asrt_valid}, 32'h0);

    // R2 R4 table walk
    for (int i = 0; i < 6; i++) begin
      logic [1:0] g;
      g = TBL[i][97:96];
      wr(A_CLR + 6'(g), 32'hFFFF_FFFF);
      wr(A_SET + 6'(g), TBL[i][95:64]);
      wr(A_MASK + 6'(g), TBL[i][63:32]);
      rd(A_FLAG + 6'(g), d); chk("R2 set flags", d, TBL[i][95:64]);
      rd(A_MFLG + 6'(g), d); chk("R4 masked", d, TBL[i][31:0]);
      settle();
      chk("R4 comb", 32'(comb_out[g]), 32'(TBL[i][31:0] != 0));
    end
    for (int g = 1; g < 4; g++) begin
      wr(A_MASK + 6'(g), 32'hFFFF_FFFF);
      wr(A_CLR + 6'(g), 32'hFFFF_FFFF);
    end
    rd(A_FLAG + 3, d); chk("R2 clear all", d, 32'h0);

    // R1 sticky edge: event 40 = group 1 bit 8
    @(negedge clk); evt_in[40] = 1;
    repeat (2) @(negedge clk); evt_in[40] = 0;
    settle();
    rd(A_FLAG + 1, d); chk("R1 sticky", d, 32'h0000_0100);

    // R3 edge and clear in same cycle on event 41
    @(negedge clk); evt_in[41] = 1; bus_wr = 1; bus_addr = A_CLR + 1; bus_wdata = 32'h200;
    @(negedge clk); bus_wr = 0; evt_in[41] = 0;
    rd(A_FLAG + 1, d); chk("R3 set wins", d, 32'h0000_0300);
    wr(A_CLR + 1, 32'h0000_0100);
    rd(A_FLAG + 1, d); chk("R2 partial clear", d, 32'h0000_0200);
    wr(A_CLR + 1, 32'hFFFF_FFFF);

    // R6 reserved low bits of group 0
    @(negedge clk); evt_in[2] = 1;
    repeat (2) @(negedge clk); evt_in[2] = 0;
    wr(A_SET + 0, 32'h0000_001F);
    rd(A_FLAG + 0, d); chk("R6 reserved", d, 32'h0000_0010);
    wr(A_CLR + 0, 32'hFFFF_FFFF);

    // R10 read-only registers ignore writes
    wr(A_FLAG + 2, 32'hFFFF_FFFF);
    wr(A_MFLG + 2, 32'hFFFF_FFFF);
    wr(A_EFLG + 2, 32'hFFFF_FFFF);
    rd(A_FLAG + 2, d); chk("R10 ro write", d, 32'h0);

    // R7 selector: reg 2 -> lines 8..11 = {0, 2, 70, 0xC8}
    wr(A_SEL + 2, 32'h0002_46C8);
    rd(A_SEL + 2, d); chk("R7 sel readback", d, 32'h0002_46C8);
    wr(A_SET + 2, 32'h0000_0040);
    settle();
    chk("R7 masked event routed", 32'(int_out), 32'h200);
    wr(A_MASK + 2, 32'hFFFF_FFBF);
    settle();
    chk("R7 comb source", 32'(int_out), 32'h600);
    chk("R4 comb2", 32'(comb_out), 32'h4);
    wr(A_MASK + 2, 32'hFFFF_FFFF);
    wr(A_CLR + 2, 32'hFFFF_FFFF);
    settle();
    chk("R7 cleared", 32'(int_out), 32'h0);

    // R8 exception path
    wr(A_EMSK + 3, 32'hFFFF_FFFE);
    wr(A_SET + 3, 32'h0000_0003);
    settle();
    chk("R8 exc high", 32'(exc_out), 32'h1);
    rd(A_EFLG + 3, d); chk("R8 masked exc", d, 32'h1);
    chk("R8 comb unaffected", 32'(comb_out), 32'h0);
    wr(A_EMSK + 3, 32'hFFFF_FFFF);
    settle();
    chk("R8 exc low", 32'(exc_out), 32'h0);

    // R9 event assert pulse
    @(negedge clk); bus_wr = 1; bus_addr = A_ASRT; bus_wdata = 32'h55;
    @(negedge clk); bus_wr = 0;
    chk("R9 pulse", {24'd0, asrt_valid, asrt_id}, {24'd0, 1'b1, 7'h55});
    @(negedge clk);
    chk("R9 one cycle", 32'(asrt_valid), 32'h0);

    done = 1;
    finish_run();
  end
endmodule